// File: doc/BRIEF.md
# Timer Compare Channel with Hardware Toggle and Watchdog

This block is one compare channel hung off a free-running 16-bit count that several channels share. Software loads a 16-bit compare value through two byte-wide register writes. The channel signals when the shared count reaches that value. In timer mode it sets a sticky flag that can raise an interrupt request. In toggle mode it also inverts an output pin directly in hardware, so the edge timing does not depend on how fast the interrupt is serviced. In watchdog mode the same event produces a one-cycle internal reset request.

Loading the low byte disarms the comparator and loading the high byte arms it again. A 16-bit update made low byte first therefore cannot match on a half-written value. A match is detected only in the cycle in which the count moves onto the compare value, so a stalled count produces no further events. If the compare value is left alone, the next event comes when the count has gone all the way round.

Registers (2-bit address): 0 = control, 1 = compare bits 7:0, 2 = compare bits 15:8, 3 = status. Control bits: bit0 interrupt enable, bit1 toggle enable, bit2 match enable, bit3 comparator armed, bit4 watchdog enable. Status bits: bit0 match flag, bit1 pin level.

Top module: `tcc_channel`

## Requirements
- R1: After reset, pin_out, irq and wdog_rst are 0, and the comparator is disarmed with every control bit cleared.
- R2: A write to address 1 disarms the comparator. Until it is re-armed, the count reaching the compare value sets no flag.
- R3: A write to address 2 arms the comparator. The full 16-bit value from both byte writes is then matched.
- R4: While armed with control bit2 set, the count changing to equal the compare value sets the match flag on the clock edge that samples it.
- R5: With control bit1 also set, every match inverts pin_out on that same edge.
- R6: A write to address 3 loads status bit1 into pin_out, which decides the direction of the next toggle. If a match and a status write fall in the same cycle, the match wins: the pin toggles from its old level and the flag is set.
- R7: When the compare value is left unchanged, the next match and toggle occur only after the count wraps through all 65536 values and returns to it.
- R8: irq is high exactly while the match flag is set and control bit0 is set.
- R9: With control bit4 set, a match drives wdog_rst high for exactly the one cycle after the sampling edge.
- R10: With control bit4 clear, a match produces no wdog_rst. Setting the bit again re-enables the pulse on the next match.
- R11: A count that holds the compare value for many cycles produces only one match event.
- R12: The match flag stays set until a status write with bit0 = 0 clears it. A status write with bit0 = 1 does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_cnt | input | 16 | Shared free-running count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data byte |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |
| wdog_rst | output | 1 | One-cycle internal reset request |

## Verification
The assertions assume the count and the write port are steady around each rising edge, and that a write selects exactly one register per cycle. They also assume the count is the only source of match events, so a count that does not change between two edges must not produce an event. The stimulus changes every input only on the falling clock edge and issues at most one register write per cycle. It moves the count through explicit values or through a full wrap, one step per cycle.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CTRL = 2'd0,
      SEL_CLO  = 2'd1,
      SEL_CHI  = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   localparam int CB_IRQ = 0;
   localparam int CB_TOG = 1;
   localparam int CB_MEN = 2;
   localparam int CB_ARM = 3;
   localparam int CB_WDG = 4;
   localparam int SB_FLAG = 0;
   localparam int SB_PIN  = 1;

   typedef struct packed {
      logic wdog_en;
      logic match_en;
      logic tog_en;
      logic irq_en;
   } ctrl_t;
endpackage

// File: rtl/tcc_regs.sv
module tcc_regs
   import tcc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output ctrl_t             ctrl,
   output logic              armed,
   output logic [CNT_W-1:0]  cmp_val,
   output logic              stat_wr,
   output logic              stat_flag_d,
   output logic              stat_pin_d
);
   localparam int NBYTES = CNT_W / BYTE_W;

   logic sel_ctrl, sel_lo, sel_hi;
   assign sel_ctrl    = wr_en && (wr_addr == SEL_CTRL);
   assign sel_lo      = wr_en && (wr_addr == SEL_CLO);
   assign sel_hi      = wr_en && (wr_addr == SEL_CHI);
   assign stat_wr     = wr_en && (wr_addr == SEL_STAT);
   assign stat_flag_d = wr_data[SB_FLAG];
   assign stat_pin_d  = wr_data[SB_PIN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (sel_ctrl) begin
         ctrl.irq_en   <= wr_data[CB_IRQ];
         ctrl.tog_en   <= wr_data[CB_TOG];
         ctrl.match_en <= wr_data[CB_MEN];
         ctrl.wdog_en  <= wr_data[CB_WDG];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        armed <= 1'b0;
      else if (sel_lo)   armed <= 1'b0;
      else if (sel_hi)   armed <= 1'b1;
      else if (sel_ctrl) armed <= wr_data[CB_ARM];
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_cmp_byte
      logic sel_b;
      assign sel_b = wr_en && (wr_addr == ADDR_W'(int'(SEL_CLO) + g));
      always_ff @(posedge clk) begin
         if (!rst_n)     cmp_val[g*BYTE_W +: BYTE_W] <= '0;
         else if (sel_b) cmp_val[g*BYTE_W +: BYTE_W] <= wr_data;
      end
   end

   assert_lo_disarms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_lo |=> !armed);
   assert_hi_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_hi |=> armed);
endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] timer_cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             armed,
   input  logic             match_en,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      cnt_q <= timer_cnt;
   end

   assign hit = armed && match_en && (timer_cnt != cnt_q) && (timer_cnt == cmp_val);

   assert_still_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(timer_cnt) |-> !hit);
   assert_disarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !hit);
endmodule

// File: rtl/tcc_events.sv
module tcc_events
   import tcc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hit,
   input  ctrl_t ctrl,
   input  logic  stat_wr,
   input  logic  stat_flag_d,
   input  logic  stat_pin_d,
   output logic  flag,
   output logic  pin,
   output logic  wdog_pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n)                     flag <= 1'b0;
      else if (hit)                   flag <= 1'b1;
      else if (stat_wr && !stat_flag_d) flag <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  pin <= 1'b0;
      else if (hit && ctrl.tog_en) pin <= ~pin;
      else if (stat_wr)            pin <= stat_pin_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wdog_pulse <= 1'b0;
      else        wdog_pulse <= hit && ctrl.wdog_en;
   end

   assert_hit_sets_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
   assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctrl.tog_en) |=> (pin != $past(pin)));
   assert_wdog_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.wdog_en |=> !wdog_pulse);
   assert_wdog_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_pulse |-> $past(hit));
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
   import tcc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int BYTE_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  timer_cnt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              pin_out,
   output logic              irq,
   output logic              wdog_rst
);
   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("tcc_channel: CNT_W must be two bytes of BYTE_W");
   end
   if (BYTE_W <= CB_WDG) begin : g_bad_byte
      $error("tcc_channel: BYTE_W too narrow for control bits");
   end

   ctrl_t            ctrl;
   logic             armed, stat_wr, stat_flag_d, stat_pin_d;
   logic [CNT_W-1:0] cmp_val;
   logic             hit, flag;

   tcc_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl(ctrl), .armed(armed), .cmp_val(cmp_val), .stat_wr(stat_wr),
      .stat_flag_d(stat_flag_d), .stat_pin_d(stat_pin_d)
   );

   tcc_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .timer_cnt(timer_cnt), .cmp_val(cmp_val),
      .armed(armed), .match_en(ctrl.match_en), .hit(hit)
   );

   tcc_events u_events (
      .clk(clk), .rst_n(rst_n), .hit(hit), .ctrl(ctrl), .stat_wr(stat_wr),
      .stat_flag_d(stat_flag_d), .stat_pin_d(stat_pin_d),
      .flag(flag), .pin(pin_out), .wdog_pulse(wdog_rst)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= flag && ctrl.irq_en;
      end
      assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(ctrl.irq_en));
   end else begin : g_irq_comb
      assign irq = flag && ctrl.irq_en;
      assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> ctrl.irq_en);
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!wdog_rst && !pin_out));
endmodule

// File: tb/tcc_channel_test.sv
module tcc_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timer_cnt = 16'h0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [7:0]  wr_data = 8'h0;
   logic        pin_out, irq, wdog_rst;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [7:0] C_IRQ = 8'h01, C_TOG = 8'h02, C_MEN = 8'h04,
                          C_ARM = 8'h08, C_WDG = 8'h10;

   always #4 clk = ~clk;

   tcc_channel uut (
      .clk(clk), .rst_n(rst_n), .timer_cnt(timer_cnt), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pin_out(pin_out), .irq(irq),
      .wdog_rst(wdog_rst)
   );

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(logic [15:0] v);
      timer_cnt = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 pin", pin_out, 1'b0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 wdog", wdog_rst, 1'b0);
      tick(16'h0001);
      tick(16'h0000);
      chk("R1 disarmed no flag", irq, 1'b0);
   endtask

   task automatic t_timer;
      wr(2'd0, C_IRQ | C_MEN);
      wr(2'd1, 8'h34);
      wr(2'd2, 8'h12);
      tick(16'h1233);
      chk("R4 before match", irq, 1'b0);
      tick(16'h1234);
      chk("R4 match sets flag", irq, 1'b1);
      wr(2'd3, 8'h01);
      chk("R12 write 1 keeps", irq, 1'b1);
      wr(2'd3, 8'h00);
      chk("R12 write 0 clears", irq, 1'b0);
      wr(2'd0, C_MEN | C_ARM);
      tick(16'h1235);
      tick(16'h1234);
      chk("R8 masked", irq, 1'b0);
      wr(2'd0, C_IRQ | C_MEN | C_ARM);
      chk("R8 unmasked pending", irq, 1'b1);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_torn;
      wr(2'd1, 8'h50);
      tick(16'h1250);
      chk("R2 disarmed after low write", irq, 1'b0);
      tick(16'h1234);
      chk("R2 old value ignored", irq, 1'b0);
      wr(2'd2, 8'h12);
      tick(16'h1251);
      chk("R3 armed no early", irq, 1'b0);
      tick(16'h1250);
      chk("R3 new value matches", irq, 1'b1);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_hold;
      for (int i = 0; i < 6; i++) @(negedge clk);
      chk("R11 held count cleared", irq, 1'b0);
      tick(16'h1250);
      chk("R11 no repeat", irq, 1'b0);
   endtask

   task automatic t_toggle;
      logic p;
      int flips;
      wr(2'd0, C_IRQ | C_TOG | C_MEN | C_ARM);
      wr(2'd3, 8'h02);
      chk("R6 pin written high", pin_out, 1'b1);
      tick(16'h124F);
      tick(16'h1250);
      chk("R5 toggled low", pin_out, 1'b0);
      p = pin_out;
      flips = 0;
      for (int k = 1; k <= 65536; k++) begin
         timer_cnt = 16'h1250 + 16'(k);
         @(negedge clk);
         if (pin_out != p) begin flips++; p = pin_out; end
         if (k == 65535) chk("R7 no toggle before wrap", pin_out, 1'b0);
      end
      chk("R7 toggled after wrap", pin_out, 1'b1);
      n_chk++;
      if (flips != 1) begin
         n_bad++;
         $display("FAIL R7 toggle count: got %0d expected 1", flips);
      end
      wr(2'd3, 8'h02);
      timer_cnt = 16'h1251;
      @(negedge clk);
      timer_cnt = 16'h1250;
      wr(2'd3, 8'h00);
      chk("R6 same-cycle pin", pin_out, 1'b0);
      chk("R6 same-cycle flag", irq, 1'b1);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_wdog;
      wr(2'd0, C_WDG | C_MEN | C_ARM);
      tick(16'h1251);
      chk("R9 idle", wdog_rst, 1'b0);
      tick(16'h1250);
      chk("R9 pulse", wdog_rst, 1'b1);
      @(negedge clk);
      chk("R9 single cycle", wdog_rst, 1'b0);
      wr(2'd0, C_MEN | C_ARM);
      tick(16'h1251);
      tick(16'h1250);
      chk("R10 suppressed", wdog_rst, 1'b0);
      wr(2'd0, C_WDG | C_MEN | C_ARM);
      tick(16'h1251);
      tick(16'h1250);
      chk("R10 re-enabled", wdog_rst, 1'b1);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 190000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timer();
      t_torn();
      t_hold();
      t_toggle();
      t_wdog();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule